// File: doc/BRIEF.md
# Single-Slope PWM Timer

This block is an up-counting timer that produces edge-aligned pulse-width waveforms on two compare channels, A and B. The counter advances by one on each timer tick, a one-cycle enable pulse supplied by an external prescaler. It counts from zero up to a period limit and then returns to zero. The limit is either the counter's full scale or the active compare value of channel A, chosen by a 3-bit mode input. Mode values other than the two PWM values park the timer.

Compare values are written into holding registers. The active copies reload from the holding registers only when the counter wraps, so a duty or period change never produces a shortened or split pulse. While the timer is parked, the active copies follow the holding registers on every clock.

Each channel's waveform is set by a 2-bit output mode: off, toggle, clear-on-match or set-on-match. Three sticky flags (overflow, match A, match B) record timer events. Each flag is cleared by pulsing its bit on a clear input. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `fpwm_timer`

## Requirements
- R1: Mode 3 runs the timer with period limit 0xFF. Mode 7 runs it with the active channel A compare value as the limit. Any other mode value freezes the counter, and ticks then set no flag and move no waveform.
- R2: While running, each tick adds one to the counter. The tick taken while the counter equals the limit returns it to 0. The counter does not change on a cycle without a tick.
- R3: The overflow flag is set by the tick taken while the counter equals the limit, so it becomes 1 in the same cycle the counter shows 0.
- R4: Output mode 2 (clear-on-match): the waveform goes to 1 on the wrapping tick and to 0 on the tick taken while the counter equals the channel's active compare value. When both happen on one tick, the waveform goes to 1, so a compare value equal to the limit gives a constant 1.
- R5: Output mode 3 (set-on-match): the waveform goes to 0 on the wrapping tick and to 1 on the tick taken at a compare match. When both happen on one tick, the waveform goes to 0.
- R6: Output mode 1 on channel A inverts waveform A on each match tick when the mode input is 7. With mode input 3, waveform A holds its value.
- R7: Output mode 1 on channel B leaves waveform B unchanged.
- R8: Output mode 0 drives the channel's waveform to 0 on the next clock, with or without ticks.
- R9: While running, a written compare value takes effect only after the next wrapping tick. While parked, it takes effect on the next clock.
- R10: A channel's match flag is set by a tick taken while the counter equals that channel's active compare value.
- R11: Clear input bits (bit 0 overflow, bit 1 match A, bit 2 match B) clear the corresponding flag on the next clock. A flag being set on the same clock stays set.
- R12: After reset, the counter, all flags, both waveforms and all compare registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable pulse from the prescaler |
| mode | input | 3 | Waveform mode (3 or 7 run, others park) |
| cmp_a_we | input | 1 | Write strobe for channel A holding register |
| cmp_a_wdata | input | W | Channel A compare value to write |
| cmp_b_we | input | 1 | Write strobe for channel B holding register |
| cmp_b_wdata | input | W | Channel B compare value to write |
| out_mode_a | input | 2 | Channel A output mode |
| out_mode_b | input | 2 | Channel B output mode |
| flag_clr | input | 3 | Flag clear pulses: bit0 overflow, bit1 match A, bit2 match B |
| count | output | W | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_a_flag | output | 1 | Sticky channel A match flag |
| match_b_flag | output | 1 | Sticky channel B match flag |

## Verification
The properties assume that tick, mode, compare writes and clear pulses are synchronous single-clock values. They also assume the counter never starts above the limit when the limit is taken from channel A, because otherwise it climbs to full scale before wrapping. The stimulus changes all inputs on the falling clock edge. It switches the mode only while the counter is at zero or the timer is parked, and it loads new compare values either while parked or mid-period so that the buffering can be observed.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    OUT_OFF        = 2'd0,
    OUT_TOGGLE     = 2'd1,
    OUT_CLR_ON_HIT = 2'd2,
    OUT_SET_ON_HIT = 2'd3
  } out_mode_e;

  localparam logic [2:0] MODE_FULL_TOP = 3'd3;
  localparam logic [2:0] MODE_VAR_TOP  = 3'd7;
  localparam int unsigned NUM_CH       = 2;
endpackage

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] top_val,
  input  logic         clr_ovf,
  output logic [W-1:0] count,
  output logic         at_top,
  output logic         ovf_flag
);
  logic step;
  logic wrap;

  assign step   = run && tick;
  assign at_top = (count == top_val);
  assign wrap   = step && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= at_top ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (wrap) begin
      ovf_flag <= 1'b1;
    end else if (clr_ovf) begin
      ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fpwm_cmp_buf.sv
module fpwm_cmp_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (we) begin
      hold_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (load) begin
      active <= hold_q;
    end
  end
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
  import fpwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         at_top,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   out_mode,
  input  logic         toggle_en,
  input  logic         clr_flag,
  output logic         wave,
  output logic         match_flag
);
  out_mode_e om;
  logic      hit;
  logic      wrap;
  logic      wave_d;

  assign om   = out_mode_e'(out_mode);
  assign hit  = step && (count == cmp);
  assign wrap = step && at_top;

  always_comb begin
    wave_d = wave;
    case (om)
      OUT_OFF:        wave_d = 1'b0;
      OUT_TOGGLE:     if (hit && toggle_en) wave_d = ~wave;
      OUT_CLR_ON_HIT: if (wrap) wave_d = 1'b1; else if (hit) wave_d = 1'b0;
      OUT_SET_ON_HIT: if (wrap) wave_d = 1'b0; else if (hit) wave_d = 1'b1;
      default:        wave_d = wave;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave <= 1'b0;
    end else begin
      wave <= wave_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
    end else if (hit) begin
      match_flag <= 1'b1;
    end else if (clr_flag) begin
      match_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic         cmp_a_we,
  input  logic [W-1:0] cmp_a_wdata,
  input  logic         cmp_b_we,
  input  logic [W-1:0] cmp_b_wdata,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  input  logic [2:0]   flag_clr,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         match_a_flag,
  output logic         match_b_flag
);
  localparam logic [W-1:0] FULL_SCALE = '1;

  logic         run;
  logic         step;
  logic         at_top;
  logic         load;
  logic [W-1:0] top_val;
  logic [W-1:0] cmp_act_a;
  logic [W-1:0] cmp_act_b;

  logic         we_v    [NUM_CH];
  logic [W-1:0] wd_v    [NUM_CH];
  logic [1:0]   om_v    [NUM_CH];
  logic [W-1:0] act_v   [NUM_CH];
  logic         wave_v  [NUM_CH];
  logic         flag_v  [NUM_CH];

  assign run     = (mode == MODE_FULL_TOP) || (mode == MODE_VAR_TOP);
  assign step    = run && tick;
  assign top_val = (mode == MODE_VAR_TOP) ? cmp_act_a : FULL_SCALE;
  assign load    = !run || (step && at_top);

  assign we_v[0] = cmp_a_we;
  assign we_v[1] = cmp_b_we;
  assign wd_v[0] = cmp_a_wdata;
  assign wd_v[1] = cmp_b_wdata;
  assign om_v[0] = out_mode_a;
  assign om_v[1] = out_mode_b;

  fpwm_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .top_val  (top_val),
    .clr_ovf  (flag_clr[0]),
    .count    (count),
    .at_top   (at_top),
    .ovf_flag (ovf_flag)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic tog_en;
    if (c == 0) begin : g_tog
      assign tog_en = mode[2];
    end else begin : g_notog
      assign tog_en = 1'b0;
    end

    fpwm_cmp_buf #(.W(W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we_v[c]),
      .wdata  (wd_v[c]),
      .load   (load),
      .active (act_v[c])
    );

    fpwm_channel #(.W(W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .at_top     (at_top),
      .count      (count),
      .cmp        (act_v[c]),
      .out_mode   (om_v[c]),
      .toggle_en  (tog_en),
      .clr_flag   (flag_clr[c+1]),
      .wave       (wave_v[c]),
      .match_flag (flag_v[c])
    );
  end

  assign cmp_act_a    = act_v[0];
  assign cmp_act_b    = act_v[1];
  assign wave_a       = wave_v[0];
  assign wave_b       = wave_v[1];
  assign match_a_flag = flag_v[0];
  assign match_b_flag = flag_v[1];
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk
  import fpwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [2:0]   mode,
  input logic [W-1:0] count,
  input logic [W-1:0] top_val,
  input logic [W-1:0] cmp_act_b,
  input logic [1:0]   out_mode_a,
  input logic [1:0]   out_mode_b,
  input logic         wave_a,
  input logic         wave_b,
  input logic         ovf_flag,
  input logic         match_b_flag
);
  logic running;
  assign running = (mode == MODE_FULL_TOP) || (mode == MODE_VAR_TOP);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count != top_val) |=> count == W'($past(count) + 1'b1));

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count == top_val) |=> count == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && tick) |=> $stable(count));

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count == top_val) |=> ovf_flag);

  a_r7_b_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_b == 2'd1) |=> $stable(wave_b));

  a_r8_off_a: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_a == 2'd0) |=> !wave_a);

  a_r8_off_b: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_b == 2'd0) |=> !wave_b);

  a_r9_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(tick && count == top_val)) |=> $stable(cmp_act_b));

  a_r10_match_b: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count == cmp_act_b) |=> match_b_flag);
endmodule

bind fpwm_timer fpwm_timer_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .mode         (mode),
  .count        (count),
  .top_val      (top_val),
  .cmp_act_b    (cmp_act_b),
  .out_mode_a   (out_mode_a),
  .out_mode_b   (out_mode_b),
  .wave_a       (wave_a),
  .wave_b       (wave_b),
  .ovf_flag     (ovf_flag),
  .match_b_flag (match_b_flag)
);

// File: tb/fpwm_timer_bench.sv
module fpwm_timer_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic         cmp_a_we = 1'b0;
  logic [W-1:0] cmp_a_wdata = '0;
  logic         cmp_b_we = 1'b0;
  logic [W-1:0] cmp_b_wdata = '0;
  logic [1:0]   out_mode_a = 2'd0;
  logic [1:0]   out_mode_b = 2'd0;
  logic [2:0]   flag_clr = 3'd0;
  logic [W-1:0] count;
  logic         wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fpwm_timer #(.W(W)) u_fpwm_timer (
    .clk, .rst_n, .tick, .mode, .cmp_a_we, .cmp_a_wdata, .cmp_b_we, .cmp_b_wdata,
    .out_mode_a, .out_mode_b, .flag_clr, .count, .wave_a, .wave_b, .ovf_flag,
    .match_a_flag, .match_b_flag
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(int ch, int val);
    @(negedge clk);
    if (ch == 0) begin cmp_a_we = 1'b1; cmp_a_wdata = W'(val); end
    else         begin cmp_b_we = 1'b1; cmp_b_wdata = W'(val); end
    @(negedge clk);
    cmp_a_we = 1'b0;
    cmp_b_we = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  task automatic t_reset();
    chk("R12", "count", int'(count), 0);
    chk("R12", "flags", int'({ovf_flag, match_a_flag, match_b_flag}), 0);
    chk("R12", "waves", int'({wave_a, wave_b}), 0);
  endtask

  task automatic t_parked();
    mode = 3'd0;
    ticks(5);
    chk("R1", "parked count", int'(count), 0);
    chk("R1", "parked flags", int'({ovf_flag, match_a_flag, match_b_flag}), 0);
  endtask

  task automatic t_full_top();
    wr_cmp(0, 10);
    wr_cmp(1, 20);
    out_mode_a = 2'd2;
    out_mode_b = 2'd3;
    idle(2);
    mode = 3'd3;
    ticks(255);
    chk("R2", "count at limit", int'(count), 255);
    chk("R3", "ovf before wrap", int'(ovf_flag), 0);
    chk("R10", "match A flag", int'(match_a_flag), 1);
    chk("R10", "match B flag", int'(match_b_flag), 1);
    chk("R5", "wave B after match", int'(wave_b), 1);
    ticks(1);
    chk("R2", "wrap to zero", int'(count), 0);
    chk("R3", "ovf on wrap", int'(ovf_flag), 1);
    chk("R4", "wave A set at wrap", int'(wave_a), 1);
    chk("R5", "wave B cleared at wrap", int'(wave_b), 0);
    for (int i = 1; i < 256; i++) begin
      ticks(1);
      chk("R2", "count step", int'(count), i);
      chk("R4", "wave A duty", int'(wave_a), (i <= 10) ? 1 : 0);
      chk("R5", "wave B duty", int'(wave_b), (i > 20) ? 1 : 0);
      if (i == 100) begin
        idle(4);
        chk("R2", "no tick hold", int'(count), 100);
      end
    end
    ticks(1);
    chk("R2", "second wrap", int'(count), 0);
  endtask

  task automatic t_flags();
    clear_flags();
    chk("R11", "flags cleared", int'({ovf_flag, match_a_flag, match_b_flag}), 0);
    ticks(255);
    @(negedge clk) begin tick = 1'b1; flag_clr = 3'b001; end
    @(negedge clk) begin tick = 1'b0; flag_clr = 3'b000; end
    chk("R11", "set wins over clear", int'(ovf_flag), 1);
    chk("R2", "count after wrap", int'(count), 0);
  endtask

  task automatic t_cmp_at_top();
    wr_cmp(0, 255);
    ticks(255);
    chk("R9", "old compare still active", int'(wave_a), 0);
    ticks(1);
    chk("R4", "wave A at wrap", int'(wave_a), 1);
    ticks(255);
    chk("R4", "compare at limit keeps high", int'(wave_a), 1);
    ticks(1);
    chk("R4", "set wins at limit", int'(wave_a), 1);
    chk("R2", "count zero", int'(count), 0);
  endtask

  task automatic t_var_top();
    mode = 3'd0;
    out_mode_a = 2'd0;
    out_mode_b = 2'd0;
    wr_cmp(0, 5);
    wr_cmp(1, 2);
    idle(2);
    chk("R8", "wave A off", int'(wave_a), 0);
    chk("R8", "wave B off", int'(wave_b), 0);
    clear_flags();
    out_mode_a = 2'd1;
    out_mode_b = 2'd2;
    mode = 3'd7;
    ticks(5);
    chk("R1", "count at var limit", int'(count), 5);
    chk("R6", "wave A before toggle", int'(wave_a), 0);
    ticks(1);
    chk("R1", "wrap at var limit", int'(count), 0);
    chk("R3", "ovf at var limit", int'(ovf_flag), 1);
    chk("R6", "wave A toggled", int'(wave_a), 1);
    ticks(6);
    chk("R6", "wave A toggled back", int'(wave_a), 0);
    ticks(6);
    chk("R6", "wave A toggled again", int'(wave_a), 1);
    chk("R4", "wave B set at wrap", int'(wave_b), 1);
    ticks(3);
    chk("R4", "wave B cleared at match", int'(wave_b), 0);
    wr_cmp(0, 3);
    ticks(2);
    chk("R9", "old limit still active", int'(count), 5);
    ticks(1);
    chk("R9", "wrap at old limit", int'(count), 0);
    ticks(3);
    chk("R9", "count at new limit", int'(count), 3);
    ticks(1);
    chk("R9", "wrap at new limit", int'(count), 0);
  endtask

  task automatic t_hold_modes();
    logic w0;
    mode = 3'd3;
    w0 = wave_a;
    clear_flags();
    ticks(3);
    chk("R10", "no match yet", int'(match_a_flag), 0);
    ticks(1);
    chk("R10", "match A at compare", int'(match_a_flag), 1);
    ticks(252);
    chk("R6", "no toggle in mode 3", int'(wave_a), int'(w0));
    chk("R4", "wave B high after wrap", int'(wave_b), 1);
    out_mode_b = 2'd1;
    ticks(10);
    chk("R7", "wave B held past match", int'(wave_b), 1);
    ticks(246);
    chk("R7", "wave B held past wrap", int'(wave_b), 1);
    out_mode_b = 2'd0;
    idle(1);
    chk("R8", "wave B off at once", int'(wave_b), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_parked();
    t_full_top();
    t_flags();
    t_cmp_at_top();
    t_var_top();
    t_hold_modes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule